// File: doc/BRIEF.md
# AES-128 Round Key Stepper

This block generates the AES-128 key schedule one round key at a time, alongside an iterative encryption core. It keeps only the current round key in four 32-bit word registers and does not store the full eleven-key schedule. A load strobe places the 128-bit cipher key in those registers. That key serves unchanged as the key for the initial whitening XOR. After that, each advance strobe from the core's round counter replaces the registers with the next round key, so the key for round N appears one clock after the N-th advance.

Each step derives the new first word from the last word of the previous key. That word is rotated left by one byte, passed through a private four-lane byte substitution path and XORed with a round constant. The round constant doubles in GF(2^8) on every step. The other three words are then chained from the new first word. Once the tenth round key has been produced, the block refuses further advances until a new key is loaded.

Top module: `aes128_key_stepper`

## Requirements
- R1: After synchronous reset the round key output is all zero, and advance strobes have no effect on the output until the first load.
- R2: When the load strobe is high at a clock edge, the output after that edge equals the cipher key input. Word 0 is bits 127:96, and word 3 is bits 31:0. Load takes priority over a simultaneous advance.
- R3: On an accepted advance, new word 0 = old word 0 XOR SubWord(RotWord(old word 3)) XOR {Rcon, 24'h0}. Each new word i (i = 1..3) = old word i XOR new word i-1.
- R4: RotWord moves the top byte (bits 31:24) of the word to the bottom byte. SubWord applies the standard AES byte S-box to each of the four bytes. The round constant is 01 for the first advance after a load and doubles in GF(2^8) with reduction polynomial 0x11B on each later advance (01,02,04,08,10,20,40,80,1B,36).
- R5: In a cycle with neither strobe high, the output keeps its value.
- R6: After ten accepted advances since the last load, further advances leave the output unchanged until the next load.
- R7: For the cipher key 2b7e151628aed2a6abf7158809cf4f3c, the first round key is a0fafe1788542cb123a339392a6c7605 and the tenth is d014f9a8c9ee2589e13f0cc8b6630ca6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Copy the cipher key into the word registers and restart the schedule |
| key_i | input | 128 | Cipher key, word 0 in the top 32 bits |
| adv_i | input | 1 | Step to the next round key |
| rkey_o | output | 128 | Current round key, registered |

## Verification
The bench goes after the round-constant wrap from 80 to 1B. A design that doubled without reduction would give wrong keys from round 9 onwards. An eleventh advance is also driven: a design that does not stop would leave the tenth key and run into a junk constant. Loads are placed mid-schedule and together with an advance, to catch a constant register that is not restarted or a loss of priority. These would show as wrong keys after a reload or a stepped key where the raw key was expected. Advances before the first load are tried, and a wrong byte direction in the rotation is caught by the known-answer vector.

// File: rtl/aes_kx_pkg.sv
package aes_kx_pkg;
  localparam int BYTE_W = 8;

  // GF(2^8) doubling with reduction polynomial 0x11B
  function automatic logic [7:0] gf_dbl(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1B : 8'h00);
  endfunction

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc;
    logic [7:0] sh;
    acc = 8'h00;
    sh  = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) acc = acc ^ sh;
      sh = gf_dbl(sh);
    end
    return acc;
  endfunction

  // multiplicative inverse as a^254; zero maps to zero
  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    localparam logic [7:0] EXP = 8'hFE;
    r = 8'h01;
    for (int i = 7; i >= 0; i--) begin
      r = gf_mul(r, r);
      if (EXP[i]) r = gf_mul(r, a);
    end
    return r;
  endfunction

  function automatic logic [7:0] sbox_fwd(input logic [7:0] a);
    logic [7:0] v;
    logic [7:0] o;
    v = gf_inv(a);
    o = v ^ {v[6:0], v[7]} ^ {v[5:0], v[7:6]} ^ {v[4:0], v[7:5]} ^ {v[3:0], v[7:4]};
    return o ^ 8'h63;
  endfunction
endpackage

// File: rtl/aes_kx_subword.sv
module aes_kx_subword #(
  parameter int WORD_W = 32
) (
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout
);
  import aes_kx_pkg::*;
  localparam int LANES = WORD_W / BYTE_W;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb dout[g*BYTE_W +: BYTE_W] = sbox_fwd(din[g*BYTE_W +: BYTE_W]);
  end
endmodule

// File: rtl/aes_kx_ctl.sv
module aes_kx_ctl #(
  parameter int ROUNDS = 10
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       load_i,
  input  logic       adv_i,
  output logic       step_o,
  output logic [7:0] rcon_o
);
  import aes_kx_pkg::*;
  localparam int RW = $clog2(ROUNDS + 1);
  localparam logic [RW-1:0] LAST = RW'(ROUNDS);

  logic [RW-1:0] round_q;
  logic [7:0]    rcon_q;

  always_comb step_o = adv_i && !load_i && (round_q != LAST);
  always_comb rcon_o = rcon_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      round_q <= LAST;
      rcon_q  <= 8'h01;
    end else if (load_i) begin
      round_q <= '0;
      rcon_q  <= 8'h01;
    end else if (step_o) begin
      round_q <= round_q + 1'b1;
      rcon_q  <= gf_dbl(rcon_q);
    end
  end

  assert_round_bound_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    round_q <= LAST);
  assert_rcon_restart_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> rcon_q == 8'h01);
  assert_no_step_done_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (round_q == LAST) |-> !step_o);
endmodule

// File: rtl/aes_kx_chain.sv
module aes_kx_chain #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4
) (
  input  logic [NWORDS*WORD_W-1:0] cur_i,
  input  logic [WORD_W-1:0]        mix_i,
  output logic [NWORDS*WORD_W-1:0] nxt_o
);
  // word k sits at bits [(NWORDS-k)*WORD_W-1 -: WORD_W]
  logic [WORD_W-1:0] w_new [NWORDS];

  for (genvar k = 0; k < NWORDS; k++) begin : g_word
    if (k == 0) begin : g_first
      always_comb w_new[k] = cur_i[(NWORDS-k)*WORD_W-1 -: WORD_W] ^ mix_i;
    end else begin : g_rest
      always_comb w_new[k] = cur_i[(NWORDS-k)*WORD_W-1 -: WORD_W] ^ w_new[k-1];
    end
    always_comb nxt_o[(NWORDS-k)*WORD_W-1 -: WORD_W] = w_new[k];
  end
endmodule

// File: rtl/aes128_key_stepper.sv
module aes128_key_stepper #(
  parameter int WORD_W = 32,
  parameter int NWORDS = 4,
  parameter int ROUNDS = 10
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     load_i,
  input  logic [NWORDS*WORD_W-1:0] key_i,
  input  logic                     adv_i,
  output logic [NWORDS*WORD_W-1:0] rkey_o
);
  import aes_kx_pkg::*;
  localparam int KEY_W = NWORDS * WORD_W;

  logic [KEY_W-1:0]  key_q;
  logic [KEY_W-1:0]  key_nxt;
  logic [WORD_W-1:0] last_w, rot_w, sub_w, mix_w;
  logic [7:0]        rcon;
  logic              step;

  aes_kx_ctl #(.ROUNDS(ROUNDS)) u_ctl (
    .clk_i(clk_i), .rst_i(rst_i), .load_i(load_i), .adv_i(adv_i),
    .step_o(step), .rcon_o(rcon)
  );

  always_comb last_w = key_q[WORD_W-1:0];
  always_comb rot_w  = {last_w[WORD_W-BYTE_W-1:0], last_w[WORD_W-1 -: BYTE_W]};

  aes_kx_subword #(.WORD_W(WORD_W)) u_sub (.din(rot_w), .dout(sub_w));

  always_comb mix_w = sub_w ^ {rcon, {(WORD_W-BYTE_W){1'b0}}};

  aes_kx_chain #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_chain (
    .cur_i(key_q), .mix_i(mix_w), .nxt_o(key_nxt)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i)       key_q <= '0;
    else if (load_i) key_q <= key_i;
    else if (step)   key_q <= key_nxt;
  end

  always_comb rkey_o = key_q;

  assert_load_copy_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    load_i |=> rkey_o == $past(key_i));
  assert_hold_idle_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !adv_i) |=> $stable(rkey_o));
  assert_chain_w1_R3: assert property (@(posedge clk_i) disable iff (rst_i)
    step |=> rkey_o[KEY_W-WORD_W-1 -: WORD_W] ==
             ($past(rkey_o[KEY_W-WORD_W-1 -: WORD_W]) ^ rkey_o[KEY_W-1 -: WORD_W]));
  assert_ignore_done_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (adv_i && !load_i && !step) |=> $stable(rkey_o));
endmodule

// File: tb/aes128_key_stepper_tb.sv
module aes128_key_stepper_tb_top;
  logic         clk = 1'b0;
  logic         rst, load, adv;
  logic [127:0] key;
  logic [127:0] rkey;

  int checks = 0;
  int errors = 0;

  logic [127:0] m_key;
  int           m_round;
  logic [7:0]   m_rcon;

  always #2 clk = ~clk;

  aes128_key_stepper dut_i (
    .clk_i(clk), .rst_i(rst), .load_i(load), .key_i(key), .adv_i(adv), .rkey_o(rkey)
  );

  function automatic logic [7:0] b_dbl(input logic [7:0] a);
    return a[7] ? (({a[6:0], 1'b0}) ^ 8'h1B) : {a[6:0], 1'b0};
  endfunction

  function automatic logic [7:0] b_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] r = 0;
    logic [7:0] x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) r ^= x;
      x = b_dbl(x);
    end
    return r;
  endfunction

  function automatic logic [7:0] b_sbox(input logic [7:0] a);
    logic [7:0] inv = 8'h00;
    logic [7:0] s;
    for (int y = 1; y < 256; y++)
      if (b_mul(a, 8'(y)) == 8'h01) inv = 8'(y);
    s = 8'h63;
    for (int k = 0; k < 5; k++) s ^= (inv << k) | (inv >> (8 - k));
    return s;
  endfunction

  function automatic logic [127:0] b_next(input logic [127:0] k, input logic [7:0] rc);
    logic [31:0] t, w0, w1, w2, w3;
    t = {k[23:0], k[31:24]};
    t = {b_sbox(t[31:24]), b_sbox(t[23:16]), b_sbox(t[15:8]), b_sbox(t[7:0])};
    w0 = k[127:96] ^ t ^ {rc, 24'h0};
    w1 = k[95:64] ^ w0;
    w2 = k[63:32] ^ w1;
    w3 = k[31:0] ^ w2;
    return {w0, w1, w2, w3};
  endfunction

  task automatic chk(input string tag, input logic [127:0] got, input logic [127:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", tag, got, exp);
    end
  endtask

  // one clock: drive at negedge, update model, sample just after posedge
  task automatic cyc(input logic l, input logic a, input logic [127:0] k);
    @(negedge clk);
    load = l; adv = a; key = k;
    if (l) begin
      m_key = k; m_round = 0; m_rcon = 8'h01;
    end else if (a && m_round < 10) begin
      m_key = b_next(m_key, m_rcon); m_round++; m_rcon = b_dbl(m_rcon);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [127:0] kv;
    void'($urandom(32'd1234));
    rst = 1'b1; load = 1'b0; adv = 1'b0; key = '0;
    m_key = '0; m_round = 10; m_rcon = 8'h01;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 reset output zero", rkey, '0);
    cyc(0, 1, 128'hFFFF);
    chk("R1 advance before load ignored", rkey, '0);

    kv = 128'h2b7e151628aed2a6abf7158809cf4f3c;
    cyc(1, 0, kv);
    chk("R2 load copies key", rkey, kv);
    cyc(0, 1, '0);
    chk("R7 first round key", rkey, 128'ha0fafe1788542cb123a339392a6c7605);
    cyc(0, 0, '0);
    chk("R5 hold with no strobe", rkey, 128'ha0fafe1788542cb123a339392a6c7605);
    for (int r = 2; r <= 10; r++) begin
      cyc(0, 1, '0);
      chk("R3 R4 chained round key", rkey, m_key);
    end
    chk("R7 tenth round key", rkey, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    cyc(0, 1, '0);
    chk("R6 eleventh advance ignored", rkey, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);
    cyc(0, 1, '0);
    chk("R6 twelfth advance ignored", rkey, 128'hd014f9a8c9ee2589e13f0cc8b6630ca6);

    cyc(1, 1, kv);
    chk("R2 load wins over advance", rkey, kv);
    cyc(0, 1, '0);
    chk("R4 rcon restarted after load", rkey, 128'ha0fafe1788542cb123a339392a6c7605);

    for (int t = 0; t < 60; t++) begin
      kv = {$urandom, $urandom, $urandom, $urandom};
      cyc(1, 0, kv);
      chk("R2 random load", rkey, m_key);
      for (int c = 0; c < 30; c++) begin
        logic l, a;
        int   p = $urandom_range(0, 99);
        l = (p < 3);
        a = (p >= 3 && p < 75);
        cyc(l, a, {$urandom, $urandom, $urandom, $urandom});
        if (l) chk("R2 mid-schedule load", rkey, m_key);
        else if (a) chk("R3 R4 R6 random advance", rkey, m_key);
        else chk("R5 random idle", rkey, m_key);
      end
    end

    @(negedge clk); load = 1'b0; adv = 1'b0;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule